// File: doc/BRIEF.md
# Tagged Variable-Region Address Translation Buffer

This block is a small, fully associative translation buffer. Each request carries an address-space tag, a virtual page number and a write flag. The block answers one cycle later with exactly one outcome: a hit with the physical page number, a miss, a page fault or a protection fault. All slots are compared in parallel. A slot matches only when its stored tag equals the tag of the request.

Each slot carries a size code. One slot can therefore translate a naturally aligned region of 2^s base pages. With the default parameters a region can reach 256 pages, which is 1 MB of 4 KB pages. Inside such a region the low page-number bits pass straight from the virtual to the physical page number.

A miss is only reported outward. The surrounding logic walks its page tables and installs the translation through the refill port. Two flush inputs are provided. One empties the whole buffer. The other removes only the slots that belong to a given address-space tag.

Top module: `tlb_xlate`

## Requirements
- R1: A request presented with `lk_valid` high at a clock edge produces `rsp_valid` high in the following cycle, with the outcome registered at that edge. A cycle without `lk_valid` gives `rsp_valid` low, with all outcome flags low and `rsp_ppn` zero.
- R2: Every response raises exactly one of `rsp_hit`, `rsp_miss`, `rsp_pgflt` and `rsp_prot`. A request that matches no occupied slot gives `rsp_miss`.
- R3: `rf_size` = s installs a region of 2^s pages, and any value above MAX_LOG counts as MAX_LOG. Matching ignores the low s bits of the virtual page number. A hit returns the stored physical page number with its low s bits replaced by those of the request. `rsp_ppn` is zero on any outcome other than a hit.
- R4: A refill goes into the lowest-numbered unoccupied slot. When every slot is occupied, it replaces the slot named by a rotating pointer. After reset the pointer names slot 0, and it advances by one, with wrap-around, only on such a replacement.
- R5: A slot matches only when its stored tag equals `lk_asid`. The same page number under another tag misses.
- R6: A write request (`lk_write`=1) that matches a slot with `rf_writable`=0 gives `rsp_prot` and no hit. Reads of that slot hit, and writes to writable slots hit.
- R7: A matching slot installed with `rf_present`=0 gives `rsp_pgflt` and no hit, whether the request reads or writes.
- R8: When several slots match, the lowest-numbered one decides the outcome and the PPN, and `rsp_multi` is raised with that response.
- R9: A refill in the same cycle as a request is not visible to that request. It becomes visible from the next request on.
- R10: `fl_asid_en` removes every slot whose tag equals `fl_asid` in one cycle and leaves the other slots intact.
- R11: `fl_all` empties every slot in one cycle. A flush in the same cycle as a refill wins, and the refill is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | Translation request strobe |
| lk_asid | input | ASID_W | Address-space tag of the request |
| lk_vpn | input | VPN_W | Virtual page number of the request |
| lk_write | input | 1 | Request is a write |
| rf_en | input | 1 | Install a translation |
| rf_asid | input | ASID_W | Tag of the new slot |
| rf_vpn | input | VPN_W | Base virtual page of the new region |
| rf_ppn | input | PPN_W | Base physical page of the new region |
| rf_size | input | SZ_W | Log2 of the region size in pages |
| rf_present | input | 1 | Translation is valid (0 gives page faults) |
| rf_writable | input | 1 | Writes are allowed |
| fl_all | input | 1 | Empty the whole buffer |
| fl_asid_en | input | 1 | Empty the slots tagged `fl_asid` |
| fl_asid | input | ASID_W | Tag selected for flushing |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No slot matched |
| rsp_pgflt | output | 1 | Matched slot is not present |
| rsp_prot | output | 1 | Write to a read-only slot |
| rsp_multi | output | 1 | More than one slot matched |
| rsp_ppn | output | PPN_W | Physical page number on a hit |

## Verification
Lookups are tried against single-page slots and against a 256-page region. Reading inside the region, at its last page and one page past it separates correct masking from exact matching and from off-by-one region bounds. The same page number under a foreign tag, and a write versus a read to a read-only slot, separate tag checking and protection from plain address matching. An overlap of a region slot with a single-page slot, refills into a full buffer, a refill in the same cycle as a lookup and flushes by tag and in full tell apart the priority order, the replacement sequence and the timing of state changes.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Mask with the lowest n bits set (n saturates at 64).
  function automatic logic [63:0] low_ones(int unsigned n);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 64; i++)
      if (i < n) r[i] = 1'b1;
    return r;
  endfunction

  // Effective region exponent: size codes above the limit count as the limit.
  function automatic int unsigned eff_log(int unsigned code, int unsigned max_log);
    return (code > max_log) ? max_log : code;
  endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ASID_W  = 8,
  parameter int VPN_W   = 20,
  parameter int SZ_W    = 4,
  parameter int MAX_LOG = 8
) (
  input  logic              occ,
  input  logic [ASID_W-1:0] e_asid,
  input  logic [VPN_W-1:0]  e_vpn,
  input  logic [SZ_W-1:0]   e_size,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              match
);
  logic [VPN_W-1:0] keep;

  assign keep  = ~VPN_W'(tlb_pkg::low_ones(tlb_pkg::eff_log(int'(e_size), MAX_LOG)));
  assign match = occ && (e_asid == lk_asid) && (((e_vpn ^ lk_vpn) & keep) == '0);
endmodule

// File: rtl/tlb_prio.sv
module tlb_prio #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) idx = IDX_W'(i);
  end
  assign any = |req;
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int NUM_ENT = 4,
  parameter int ASID_W  = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int MAX_LOG = 8,
  localparam int SZ_W   = $clog2(MAX_LOG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic              lk_write,
  input  logic              rf_en,
  input  logic [ASID_W-1:0] rf_asid,
  input  logic [VPN_W-1:0]  rf_vpn,
  input  logic [PPN_W-1:0]  rf_ppn,
  input  logic [SZ_W-1:0]   rf_size,
  input  logic              rf_present,
  input  logic              rf_writable,
  input  logic              fl_all,
  input  logic              fl_asid_en,
  input  logic [ASID_W-1:0] fl_asid,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_pgflt,
  output logic              rsp_prot,
  output logic              rsp_multi,
  output logic [PPN_W-1:0]  rsp_ppn
);
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENT - 1);

  // slot storage
  logic [NUM_ENT-1:0] occ_q, pres_q, wrok_q;
  logic [ASID_W-1:0]  asid_q [NUM_ENT];
  logic [VPN_W-1:0]   vpn_q  [NUM_ENT];
  logic [PPN_W-1:0]   ppn_q  [NUM_ENT];
  logic [SZ_W-1:0]    size_q [NUM_ENT];
  logic [IDX_W-1:0]   rr_q;

  // named internal events
  logic [NUM_ENT-1:0] hit_vec;
  logic [IDX_W-1:0]   hit_idx, free_idx, victim_idx;
  logic               hit_any, free_any, hit_multi;
  logic               ev_pgflt, ev_prot, ev_hit;
  logic [PPN_W-1:0]   xl_ppn;
  logic [PPN_W-1:0]   low_mask;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    tlb_match #(.ASID_W(ASID_W), .VPN_W(VPN_W), .SZ_W(SZ_W), .MAX_LOG(MAX_LOG)) u_m (
      .occ    (occ_q[g]),
      .e_asid (asid_q[g]),
      .e_vpn  (vpn_q[g]),
      .e_size (size_q[g]),
      .lk_asid(lk_asid),
      .lk_vpn (lk_vpn),
      .match  (hit_vec[g])
    );
  end

  tlb_prio #(.N(NUM_ENT), .IDX_W(IDX_W)) u_hit_sel (
    .req(hit_vec), .idx(hit_idx), .any(hit_any)
  );

  tlb_prio #(.N(NUM_ENT), .IDX_W(IDX_W)) u_free_sel (
    .req(~occ_q), .idx(free_idx), .any(free_any)
  );

  assign victim_idx = free_any ? free_idx : rr_q;
  assign hit_multi  = (hit_vec & (hit_vec - NUM_ENT'(1))) != '0;

  assign ev_pgflt = hit_any && !pres_q[hit_idx];
  assign ev_prot  = hit_any && pres_q[hit_idx] && lk_write && !wrok_q[hit_idx];
  assign ev_hit   = hit_any && !ev_pgflt && !ev_prot;

  assign low_mask = PPN_W'(tlb_pkg::low_ones(tlb_pkg::eff_log(int'(size_q[hit_idx]), MAX_LOG)));
  assign xl_ppn   = (ppn_q[hit_idx] & ~low_mask) | (PPN_W'(lk_vpn) & low_mask);

  // slot state: flushes take precedence over a refill
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      rr_q  <= '0;
    end else if (fl_all) begin
      occ_q <= '0;
    end else if (fl_asid_en) begin
      for (int i = 0; i < NUM_ENT; i++)
        if (asid_q[i] == fl_asid) occ_q[i] <= 1'b0;
    end else if (rf_en) begin
      occ_q[victim_idx] <= 1'b1;
      if (!free_any) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rf_en && !fl_all && !fl_asid_en) begin
      asid_q[victim_idx] <= rf_asid;
      vpn_q[victim_idx]  <= rf_vpn;
      ppn_q[victim_idx]  <= rf_ppn;
      size_q[victim_idx] <= rf_size;
      pres_q[victim_idx] <= rf_present;
      wrok_q[victim_idx] <= rf_writable;
    end
  end

  // registered response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_pgflt <= 1'b0;
      rsp_prot  <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_ppn   <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && ev_hit;
      rsp_miss  <= lk_valid && !hit_any;
      rsp_pgflt <= lk_valid && ev_pgflt;
      rsp_prot  <= lk_valid && ev_prot;
      rsp_multi <= lk_valid && hit_multi;
      rsp_ppn   <= (lk_valid && ev_hit) ? xl_ppn : '0;
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int NUM_ENT = 4,
  parameter int PPN_W   = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_write,
  input logic               rf_en,
  input logic               fl_all,
  input logic               fl_asid_en,
  input logic [NUM_ENT-1:0] occ_q,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_miss,
  input logic               rsp_pgflt,
  input logic               rsp_prot,
  input logic               rsp_multi,
  input logic [PPN_W-1:0]   rsp_ppn
);
  // R1
  req_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_pgflt || rsp_prot || rsp_multi));

  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_pgflt, rsp_prot}) == 1));

  // R3
  ppn_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_ppn == '0));

  // R4
  fill_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_en && !fl_all && !fl_asid_en && (occ_q != '1))
      |=> ($countones(occ_q) == $past($countones(occ_q)) + 1));

  // R6
  prot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_prot |-> $past(lk_write));

  // R8
  multi_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi |-> !rsp_miss);

  // R11
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_all |=> (occ_q == '0));
endmodule

bind tlb_xlate tlb_xlate_chk #(.NUM_ENT(NUM_ENT), .PPN_W(PPN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_valid  (lk_valid),
  .lk_write  (lk_write),
  .rf_en     (rf_en),
  .fl_all    (fl_all),
  .fl_asid_en(fl_asid_en),
  .occ_q     (occ_q),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_miss  (rsp_miss),
  .rsp_pgflt (rsp_pgflt),
  .rsp_prot  (rsp_prot),
  .rsp_multi (rsp_multi),
  .rsp_ppn   (rsp_ppn)
);

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 0, lk_write = 0, rf_en = 0, rf_present = 0, rf_writable = 0;
  logic        fl_all = 0, fl_asid_en = 0;
  logic [7:0]  lk_asid = '0, rf_asid = '0, fl_asid = '0;
  logic [19:0] lk_vpn = '0, rf_vpn = '0, rf_ppn = '0;
  logic [3:0]  rf_size = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_pgflt, rsp_prot, rsp_multi;
  logic [19:0] rsp_ppn;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [24:0] v;   // {hit, miss, pgflt, prot, multi, ppn}
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;  // 50 MHz

  tlb_xlate u_tlb_xlate (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_vpn(lk_vpn), .lk_write(lk_write),
    .rf_en(rf_en), .rf_asid(rf_asid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn),
    .rf_size(rf_size), .rf_present(rf_present), .rf_writable(rf_writable),
    .fl_all(fl_all), .fl_asid_en(fl_asid_en), .fl_asid(fl_asid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_pgflt(rsp_pgflt), .rsp_prot(rsp_prot), .rsp_multi(rsp_multi),
    .rsp_ppn(rsp_ppn)
  );

  task automatic check(input bit ok, input string tag, input logic [24:0] act, input logic [24:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // monitor: pops one expectation per response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R1 unexpected response", 25'(1), 25'(0));
      end else begin
        exp_t e;
        logic [24:0] act;
        e   = sb.pop_front();
        act = {rsp_hit, rsp_miss, rsp_pgflt, rsp_prot, rsp_multi, rsp_ppn};
        check(act == e.v, e.tag, act, e.v);
      end
    end
  end

  task automatic clear_strobes();
    lk_valid = 0; rf_en = 0; fl_all = 0; fl_asid_en = 0;
  endtask

  // outcome codes for the expectation
  localparam logic [3:0] HIT = 4'b1000, MISS = 4'b0100, PGF = 4'b0010, PROT = 4'b0001;

  task automatic lookup(input logic [7:0] a, input logic [19:0] v, input logic w,
                        input logic [3:0] outc, input logic multi, input logic [19:0] ppn,
                        input string tag);
    exp_t e;
    @(negedge clk);
    clear_strobes();
    lk_valid = 1; lk_asid = a; lk_vpn = v; lk_write = w;
    e.v = {outc, multi, ppn};
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic refill(input logic [7:0] a, input logic [19:0] v, input logic [19:0] p,
                        input logic [3:0] s, input logic pres, input logic wr);
    @(negedge clk);
    clear_strobes();
    rf_en = 1; rf_asid = a; rf_vpn = v; rf_ppn = p; rf_size = s;
    rf_present = pres; rf_writable = wr;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      clear_strobes();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({rsp_valid, rsp_hit, rsp_miss, rsp_pgflt, rsp_prot, rsp_multi, rsp_ppn} == '0,
          "R1 reset state", 25'({rsp_hit, rsp_miss, rsp_ppn}), 25'(0));
    rst_n = 1;

    // empty buffer misses (R2)
    lookup(8'd1, 20'h00010, 0, MISS, 0, 20'h0, "R2 empty miss");
    // single page slot 0
    refill(8'd1, 20'h00010, 20'h00ABC, 4'd0, 1, 1);
    lookup(8'd1, 20'h00010, 0, HIT,  0, 20'h00ABC, "R1 basic hit");
    lookup(8'd2, 20'h00010, 0, MISS, 0, 20'h0,     "R5 foreign tag miss");
    lookup(8'd1, 20'h00011, 0, MISS, 0, 20'h0,     "R3 single page exact");
    // 256-page read-only region, slot 1
    refill(8'd1, 20'h00200, 20'h12300, 4'd8, 1, 0);
    lookup(8'd1, 20'h002A7, 0, HIT,  0, 20'h123A7, "R3 region inner page");
    lookup(8'd1, 20'h002FF, 0, HIT,  0, 20'h123FF, "R3 region last page");
    lookup(8'd1, 20'h00300, 0, MISS, 0, 20'h0,     "R3 past region end");
    lookup(8'd1, 20'h002A7, 1, PROT, 0, 20'h0,     "R6 write read-only");
    lookup(8'd1, 20'h00010, 1, HIT,  0, 20'h00ABC, "R6 write writable");
    // not-present slot 2
    refill(8'd1, 20'h00400, 20'h00777, 4'd0, 0, 1);
    lookup(8'd1, 20'h00400, 0, PGF,  0, 20'h0,     "R7 read not present");
    lookup(8'd1, 20'h00400, 1, PGF,  0, 20'h0,     "R7 write not present");
    // overlapping slot 3
    refill(8'd1, 20'h00210, 20'h55555, 4'd0, 1, 1);
    lookup(8'd1, 20'h00210, 0, HIT,  1, 20'h12310, "R8 lowest slot wins");
    lookup(8'd1, 20'h00210, 1, PROT, 1, 20'h0,     "R8 lowest slot decides fault");
    lookup(8'd1, 20'h00010, 0, HIT,  0, 20'h00ABC, "R4 first free kept slot 0");
    // full: rotating replacement, slot 0 then slot 1
    refill(8'd3, 20'h00050, 20'h00060, 4'd0, 1, 1);
    lookup(8'd1, 20'h00010, 0, MISS, 0, 20'h0,     "R4 slot 0 replaced");
    lookup(8'd3, 20'h00050, 0, HIT,  0, 20'h00060, "R4 new slot 0");
    refill(8'd3, 20'h00070, 20'h00071, 4'd0, 1, 1);
    lookup(8'd1, 20'h002A7, 0, MISS, 0, 20'h0,     "R4 slot 1 replaced");
    lookup(8'd1, 20'h00210, 0, HIT,  0, 20'h55555, "R4 slot 3 survives");
    // refill in the same cycle as a lookup (R9), replaces slot 2
    begin
      exp_t e;
      @(negedge clk);
      clear_strobes();
      rf_en = 1; rf_asid = 8'd4; rf_vpn = 20'h00900; rf_ppn = 20'h00901;
      rf_size = 4'd0; rf_present = 1; rf_writable = 1;
      lk_valid = 1; lk_asid = 8'd4; lk_vpn = 20'h00900; lk_write = 0;
      e.v = {MISS, 1'b0, 20'h0}; e.tag = "R9 same-cycle refill hidden";
      sb.push_back(e);
    end
    lookup(8'd4, 20'h00900, 0, HIT,  0, 20'h00901, "R9 refill visible next");
    // inputs held but no strobe: no response (R1)
    @(negedge clk);
    clear_strobes();
    @(negedge clk);
    check(rsp_valid == 0, "R1 no strobe no response", 25'(rsp_valid), 25'(0));
    // flush by tag 3
    @(negedge clk);
    clear_strobes();
    fl_asid_en = 1; fl_asid = 8'd3;
    lookup(8'd3, 20'h00050, 0, MISS, 0, 20'h0,     "R10 tag 3 slot gone");
    lookup(8'd3, 20'h00070, 0, MISS, 0, 20'h0,     "R10 tag 3 second slot gone");
    lookup(8'd4, 20'h00900, 0, HIT,  0, 20'h00901, "R10 other tag kept");
    lookup(8'd1, 20'h00210, 0, HIT,  0, 20'h55555, "R10 tag 1 kept");
    // full flush with a refill in the same cycle
    @(negedge clk);
    clear_strobes();
    fl_all = 1;
    rf_en = 1; rf_asid = 8'd5; rf_vpn = 20'h00A00; rf_ppn = 20'h00A01;
    rf_size = 4'd0; rf_present = 1; rf_writable = 1;
    lookup(8'd5, 20'h00A00, 0, MISS, 0, 20'h0,     "R11 refill dropped by flush");
    lookup(8'd4, 20'h00900, 0, MISS, 0, 20'h0,     "R11 all slots empty");
    // free slots refilled again, a 4-page region
    refill(8'd6, 20'h00100, 20'h00101, 4'd0, 1, 1);
    refill(8'd6, 20'h00104, 20'h00208, 4'd2, 1, 1);
    lookup(8'd6, 20'h00107, 0, HIT,  0, 20'h0020B, "R3 four-page region");
    lookup(8'd6, 20'h00100, 0, HIT,  0, 20'h00101, "R4 free slot reused");
    lookup(8'd6, 20'h00108, 0, MISS, 0, 20'h0,     "R3 four-page region end");

    idle(4);
    check(sb.size() == 0, "R1 all responses seen", 25'(sb.size()), 25'(0));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule